// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the write port of a two-bank flash array and turns bus write cycles into internal operations. Each write cycle arrives as a one-clock strobe carrying the upper address bits that select a bank, the low command byte, and the lock state of the block being addressed. Single-cycle commands change what a bank returns on reads (array, status or identifier). Multi-cycle commands (word program, page program, block erase) collect their data or confirm cycles, then fire a start pulse to the program/erase engine and hold a busy flag for a parameterised number of clocks that stands in for the real operation time.

The block keeps an 8-bit status value: engine ready, suspended, and three sticky error flags. A running operation can be suspended and resumed from its own bank, and the other bank stays readable and commandable meanwhile. A locked target or a malformed confirm cycle ends the sequence with both erase and program error flags set. A synchronous power-down input returns everything to the reset state and aborts a running operation.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After rst_n release, or one clock after pd_n is sampled low, busy_o is 0, status_o is 80h and both banks read in array mode (mode_o = 0); pd_n low aborts a running operation.
- R2: Commands FFh, 90h and 70h set the addressed bank's read mode to array (0), identifier (2) or status (1); the bank with wr_tag all ones is bank 0 (mode_o[1:0]), any other tag is bank 1 (mode_o[3:2]).
- R3: 40h followed by one data write to bank 0 gives prog_start_o for one clock after the data write, then busy_o high and SR7 low for exactly PROG_CYC clocks.
- R4: 40h addressed to bank 1 is ignored, so the next write is decoded as a command.
- R5: 41h followed by PAGE_WORDS data writes gives prog_start_o only after the last data write.
- R6: 20h followed by D0h gives erase_start_o and keeps busy_o high for exactly ERASE_CYC clocks.
- R7: Starting an operation sets its bank to status mode; while it runs, mode commands to that bank are ignored and mode commands to the other bank take effect.
- R8: A start whose final write has wr_locked high gives no start pulse, leaves status_o at B0h and sets the target bank to status mode.
- R9: A write other than D0h after 20h gives no start pulse, sets SR5 and SR4 (status B0h) and returns to command decoding.
- R10: B0h to the running bank gives susp_req_o, drops busy_o and reads status C0h with the timer frozen; B0h to the other bank is ignored.
- R11: D0h to the suspended bank gives resume_req_o, clears SR6 and SR7 and runs only the remaining clocks.
- R12: At completion a high eng_fail sets SR4 for program or SR5 for erase, and a high eng_ovp sets SR3 for program.
- R13: SR5..SR3 stay set through later operations until a 50h write clears them.
- R14: SR2..SR0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Synchronous active-low power-down / abort |
| wr_stb | input | 1 | One-clock strobe per bus write cycle |
| wr_tag | input | TAG_W | Bank-select upper address bits of the write |
| wr_cmd | input | 8 | Low data byte of the write |
| wr_locked | input | 1 | Lock state of the block addressed by the write |
| eng_fail | input | 1 | Engine reports a failed operation at completion |
| eng_ovp | input | 1 | Engine reports an over-programmed cell at completion |
| mode_o | output | 4 | Read mode per bank, 2 bits each |
| status_o | output | 8 | Status value |
| busy_o | output | 1 | Operation running |
| prog_start_o | output | 1 | Program start pulse |
| erase_start_o | output | 1 | Erase start pulse |
| susp_req_o | output | 1 | Suspend request pulse |
| resume_req_o | output | 1 | Resume request pulse |

## Verification
On every clock the assertions check that busy and the ready bit never agree, that a suspended state is ready and idle, that the request pulses are mutually exclusive and follow a write, that start pulses coincide with busy and a status-mode bank, that power-down restores the reset state, and that error flags only fall after a clear or power-down. Exact operation lengths, the frozen timer across a suspend, the ignored bank-1 word program, the page count, the locked and malformed-confirm aborts, and the error flag sources at completion can only be shown by the bench's directed scenarios.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WP_DATA,
    S_PG_DATA,
    S_ER_CONF,
    S_RUN,
    S_SUSP
  } seq_t;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_SR    = 8'h50;
  localparam logic [7:0] CMD_WORD_PROG = 8'h40;
  localparam logic [7:0] CMD_PAGE_PROG = 8'h41;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
endpackage

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                    cnt_d = '0;
    else if (load)                cnt_d = len;
    else if (run && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == W'(1));
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       set_busy,
  input  logic       set_ready,
  input  logic       set_susp,
  input  logic       clr_susp,
  input  logic [2:0] err_set,   // {erase, program, block}
  input  logic       err_clr,
  output logic [7:0] sr
);
  logic       ready_q, ready_d;
  logic       susp_q,  susp_d;
  logic [2:0] err_q,   err_d;

  always_comb begin
    ready_d = ready_q;
    susp_d  = susp_q;
    err_d   = err_q;
    if (init) begin
      ready_d = 1'b1;
      susp_d  = 1'b0;
      err_d   = '0;
    end else begin
      if (set_busy)       ready_d = 1'b0;
      else if (set_ready) ready_d = 1'b1;
      if (set_susp)       susp_d  = 1'b1;
      else if (clr_susp)  susp_d  = 1'b0;
      err_d = (err_q & ~{3{err_clr}}) | err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      ready_q <= ready_d;
      susp_q  <= susp_d;
      err_q   <= err_d;
    end
  end

  assign sr = {ready_q, susp_q, err_q, 3'b000};
endmodule

// File: rtl/fcmd_mode_bank.sv
module fcmd_mode_bank
  import fcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init,
  input  logic  force_st,
  input  logic  set_en,
  input  mode_t set_val,
  output mode_t mode
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (init)          mode_d = MODE_ARRAY;
    else if (force_st) mode_d = MODE_STATUS;
    else if (set_en)   mode_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ARRAY;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcmd_pkg::*;
#(
  parameter int              TAG_W      = 3,
  parameter logic [TAG_W-1:0] BOOT_TAG  = '1,
  parameter int              PAGE_WORDS = 128,
  parameter int              PROG_CYC   = 64,
  parameter int              ERASE_CYC  = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_n,
  input  logic                 wr_stb,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [7:0]           wr_cmd,
  input  logic                 wr_locked,
  input  logic                 eng_fail,
  input  logic                 eng_ovp,
  output logic [2*NBANK-1:0]   mode_o,
  output logic [7:0]           status_o,
  output logic                 busy_o,
  output logic                 prog_start_o,
  output logic                 erase_start_o,
  output logic                 susp_req_o,
  output logic                 resume_req_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int PG_W    = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam logic [TMR_W-1:0] PROG_LEN  = TMR_W'(PROG_CYC);
  localparam logic [TMR_W-1:0] ERASE_LEN = TMR_W'(ERASE_CYC);
  localparam logic [PG_W-1:0]  PG_LAST   = PG_W'(PAGE_WORDS - 1);
  localparam logic BANK_BOOT = 1'b0;

  seq_t            st_q, st_d;
  logic            tbank_q, tbank_d;
  logic            erase_q, erase_d;
  logic [PG_W-1:0] pg_q, pg_d;
  logic            pst_q, pst_d, est_q, est_d, sus_q, sus_d, res_q, res_d;

  logic            wbank, mode_hit, cmd_clr, start_req, seq_err;
  mode_t           m_val;
  logic [NBANK-1:0] m_set, m_force;
  logic            tmr_load, tmr_run, tmr_done;
  logic            sr_busy, sr_ready, sr_susp_set, sr_susp_clr, err_clr;
  logic [2:0]      err_set;

  assign wbank   = (wr_tag == BOOT_TAG) ? BANK_BOOT : ~BANK_BOOT;
  assign cmd_clr = (wr_cmd == CMD_CLR_SR);

  always_comb begin
    mode_hit = 1'b1;
    m_val    = MODE_ARRAY;
    case (wr_cmd)
      CMD_RD_ARRAY:  m_val = MODE_ARRAY;
      CMD_RD_IDENT:  m_val = MODE_IDENT;
      CMD_RD_STATUS: m_val = MODE_STATUS;
      default:       mode_hit = 1'b0;
    endcase
  end

  assign tmr_run = (st_q == S_RUN) && pd_n;

  always_comb begin
    st_d = st_q; tbank_d = tbank_q; erase_d = erase_q; pg_d = pg_q;
    pst_d = 1'b0; est_d = 1'b0; sus_d = 1'b0; res_d = 1'b0;
    start_req = 1'b0; seq_err = 1'b0; tmr_load = 1'b0;
    sr_busy = 1'b0; sr_ready = 1'b0; sr_susp_set = 1'b0; sr_susp_clr = 1'b0;
    err_set = '0; err_clr = 1'b0;
    m_set = '0; m_force = '0;

    if (wr_stb) begin
      case (st_q)
        S_IDLE: begin
          if (mode_hit) m_set[wbank] = 1'b1;
          if (cmd_clr)  err_clr = 1'b1;
          if (wr_cmd == CMD_WORD_PROG && wbank == BANK_BOOT) begin
            st_d = S_WP_DATA; tbank_d = wbank;
          end
          if (wr_cmd == CMD_PAGE_PROG) begin
            st_d = S_PG_DATA; tbank_d = wbank; pg_d = '0;
          end
          if (wr_cmd == CMD_ERASE) begin
            st_d = S_ER_CONF; tbank_d = wbank;
          end
        end
        S_WP_DATA: begin
          start_req = 1'b1; erase_d = 1'b0;
        end
        S_PG_DATA: begin
          if (pg_q == PG_LAST) begin
            start_req = 1'b1; erase_d = 1'b0;
          end else begin
            pg_d = pg_q + 1'b1;
          end
        end
        S_ER_CONF: begin
          if (wr_cmd == CMD_CONFIRM) begin
            start_req = 1'b1; erase_d = 1'b1;
          end else begin
            seq_err = 1'b1;
          end
        end
        S_RUN: begin
          if (!tmr_done) begin
            if (wr_cmd == CMD_SUSPEND && wbank == tbank_q) begin
              st_d = S_SUSP; sus_d = 1'b1; sr_susp_set = 1'b1; sr_ready = 1'b1;
            end else begin
              if (mode_hit && wbank != tbank_q) m_set[wbank] = 1'b1;
              if (cmd_clr) err_clr = 1'b1;
            end
          end
        end
        S_SUSP: begin
          if (wr_cmd == CMD_CONFIRM && wbank == tbank_q) begin
            st_d = S_RUN; res_d = 1'b1; sr_susp_clr = 1'b1; sr_busy = 1'b1;
          end else begin
            if (mode_hit) m_set[wbank] = 1'b1;
            if (cmd_clr)  err_clr = 1'b1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end

    if (start_req) begin
      m_force[tbank_q] = 1'b1;
      if (wr_locked) begin
        st_d = S_IDLE; err_set = 3'b110;
      end else begin
        st_d = S_RUN; tmr_load = 1'b1; sr_busy = 1'b1;
        pst_d = ~erase_d; est_d = erase_d;
      end
    end
    if (seq_err) begin
      st_d = S_IDLE; err_set = 3'b110; m_force[tbank_q] = 1'b1;
    end
    if (tmr_done) begin
      st_d = S_IDLE; sr_ready = 1'b1;
      err_set = erase_q ? {eng_fail, 2'b00} : {1'b0, eng_fail, eng_ovp};
    end
    if (!pd_n) begin
      st_d = S_IDLE; pst_d = 1'b0; est_d = 1'b0; sus_d = 1'b0; res_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; tbank_q <= BANK_BOOT; erase_q <= 1'b0; pg_q <= '0;
      pst_q <= 1'b0; est_q <= 1'b0; sus_q <= 1'b0; res_q <= 1'b0;
    end else begin
      st_q <= st_d; tbank_q <= tbank_d; erase_q <= erase_d; pg_q <= pg_d;
      pst_q <= pst_d; est_q <= est_d; sus_q <= sus_d; res_q <= res_d;
    end
  end

  fcmd_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(!pd_n), .load(tmr_load),
    .len(erase_d ? ERASE_LEN : PROG_LEN), .run(tmr_run), .done(tmr_done)
  );

  fcmd_status u_status (
    .clk(clk), .rst_n(rst_n), .init(!pd_n), .set_busy(sr_busy),
    .set_ready(sr_ready), .set_susp(sr_susp_set), .clr_susp(sr_susp_clr),
    .err_set(err_set), .err_clr(err_clr), .sr(status_o)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    mode_t bmode;
    fcmd_mode_bank u_mode (
      .clk(clk), .rst_n(rst_n), .init(!pd_n), .force_st(m_force[g]),
      .set_en(m_set[g]), .set_val(m_val), .mode(bmode)
    );
    assign mode_o[2*g +: 2] = bmode;
  end

  assign busy_o        = (st_q == S_RUN);
  assign prog_start_o  = pst_q;
  assign erase_start_o = est_q;
  assign susp_req_o    = sus_q;
  assign resume_req_o  = res_q;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_n,
  input logic             wr_stb,
  input logic [7:0]       wr_cmd,
  input logic [3:0]       mode_o,
  input logic [7:0]       status_o,
  input logic             busy_o,
  input logic             prog_start_o,
  input logic             erase_start_o,
  input logic             susp_req_o,
  input logic             resume_req_o
);
  // R3: a running engine is never reported ready
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !status_o[7]);

  // R10: suspended means ready and not busy
  a_r10_susp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] |-> (status_o[7] && !busy_o));

  // R10/R11: request pulses are exclusive and follow a write
  a_r11_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start_o, erase_start_o, susp_req_o, resume_req_o}));
  a_r11_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start_o || erase_start_o || susp_req_o || resume_req_o) |-> $past(wr_stb));

  // R7: a start coincides with busy and a bank in status mode
  a_r7_start_status: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start_o || erase_start_o) |->
      (busy_o && (mode_o[1:0] == 2'd1 || mode_o[3:2] == 2'd1)));

  // R1: power-down restores the reset state
  a_r1_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!busy_o && status_o == 8'h80 && mode_o == 4'd0));

  // R13: error flags only fall after a clear write or power-down
  a_r13_sticky_ers: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[5]) |-> ($past(wr_stb && wr_cmd == 8'h50) || !$past(pd_n)));
  a_r13_sticky_prg: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[4]) |-> ($past(wr_stb && wr_cmd == 8'h50) || !$past(pd_n)));
  a_r13_sticky_blk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[3]) |-> ($past(wr_stb && wr_cmd == 8'h50) || !$past(pd_n)));
endmodule

bind flash_cmd_fsm fcmd_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wr_stb(wr_stb), .wr_cmd(wr_cmd),
  .mode_o(mode_o), .status_o(status_o), .busy_o(busy_o),
  .prog_start_o(prog_start_o), .erase_start_o(erase_start_o),
  .susp_req_o(susp_req_o), .resume_req_o(resume_req_o)
);

// File: tb/flash_cmd_fsm_test.sv
`timescale 1ns/1ps
module flash_cmd_fsm_test;
  localparam int PROG_CYC = 12;
  localparam int ERASE_CYC = 20;
  localparam int PAGE_WORDS = 4;
  localparam logic [2:0] T0 = 3'b111;
  localparam logic [2:0] T1 = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_n = 1'b1, wr_stb = 1'b0, wr_locked = 1'b0;
  logic eng_fail = 1'b0, eng_ovp = 1'b0;
  logic [2:0] wr_tag = '0;
  logic [7:0] wr_cmd = '0;
  logic [3:0] mode_o;
  logic [7:0] status_o;
  logic busy_o, prog_start_o, erase_start_o, susp_req_o, resume_req_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_fsm #(.PAGE_WORDS(PAGE_WORDS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wr_stb(wr_stb), .wr_tag(wr_tag),
    .wr_cmd(wr_cmd), .wr_locked(wr_locked), .eng_fail(eng_fail), .eng_ovp(eng_ovp),
    .mode_o(mode_o), .status_o(status_o), .busy_o(busy_o),
    .prog_start_o(prog_start_o), .erase_start_o(erase_start_o),
    .susp_req_o(susp_req_o), .resume_req_o(resume_req_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] tag, input logic [7:0] cmd, input logic lk);
    @(negedge clk);
    wr_stb = 1'b1; wr_tag = tag; wr_cmd = cmd; wr_locked = lk;
    @(negedge clk);
    wr_stb = 1'b0; wr_locked = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 8'h80);
    chk("R1 mode", mode_o, 0);
    chk("R1 busy", busy_o, 0);
  endtask

  task automatic t_modes;
    wr(T1, 8'h90, 0); chk("R2 bank1 ident", mode_o, 4'b1000);
    wr(T0, 8'h70, 0); chk("R2 bank0 status", mode_o, 4'b1001);
    wr(T0, 8'hFF, 0); chk("R2 bank0 array", mode_o[1:0], 0);
    wr(T1, 8'hFF, 0); chk("R2 bank1 array", mode_o, 0);
  endtask

  task automatic t_word;
    int n;
    wr(T0, 8'h40, 0);
    chk("R3 no early start", prog_start_o, 0);
    wr(T0, 8'h5A, 0);
    chk("R3 prog start", prog_start_o, 1);
    chk("R3 status busy", status_o, 8'h00);
    chk("R7 bank0 status", mode_o[1:0], 1);
    wait_idle(n);
    chk("R3 duration", n, PROG_CYC);
    chk("R3 ready", status_o, 8'h80);
    wr(T0, 8'hFF, 0);
  endtask

  task automatic t_word_bank1;
    wr(T1, 8'h40, 0);
    wr(T1, 8'h70, 0);
    chk("R4 no start", prog_start_o, 0);
    chk("R4 decoded as command", mode_o[3:2], 1);
    chk("R4 idle", busy_o, 0);
    wr(T1, 8'hFF, 0);
  endtask

  task automatic t_page;
    int n;
    wr(T1, 8'h41, 0);
    for (int i = 0; i < PAGE_WORDS - 1; i++) begin
      wr(T1, 8'(i), 0);
      chk("R5 no start mid page", prog_start_o, 0);
    end
    wr(T1, 8'h33, 0);
    chk("R5 start after last", prog_start_o, 1);
    chk("R7 bank1 status", mode_o[3:2], 1);
    wr(T1, 8'hFF, 0);
    chk("R7 busy bank mode held", mode_o[3:2], 1);
    wr(T0, 8'h90, 0);
    chk("R7 other bank ident", mode_o[1:0], 2);
    wait_idle(n);
    wr(T0, 8'hFF, 0); wr(T1, 8'hFF, 0);
  endtask

  task automatic t_erase;
    int n;
    wr(T1, 8'h20, 0);
    wr(T1, 8'hD0, 0);
    chk("R6 erase start", erase_start_o, 1);
    chk("R6 no prog start", prog_start_o, 0);
    wait_idle(n);
    chk("R6 duration", n, ERASE_CYC);
    wr(T1, 8'hFF, 0);
  endtask

  task automatic t_suspend;
    int n;
    wr(T0, 8'h20, 0);
    wr(T0, 8'hD0, 0);
    repeat (4) @(negedge clk);
    wr(T1, 8'hB0, 0);
    chk("R10 wrong bank ignored", susp_req_o, 0);
    chk("R10 still busy", busy_o, 1);
    wr(T0, 8'hB0, 0);
    chk("R10 suspend req", susp_req_o, 1);
    chk("R10 status", status_o, 8'hC0);
    repeat (5) @(negedge clk);
    chk("R10 held", {busy_o, status_o}, 9'h0C0);
    wr(T0, 8'hFF, 0);
    chk("R10 read array while suspended", mode_o[1:0], 0);
    wr(T0, 8'hD0, 0);
    chk("R11 resume req", resume_req_o, 1);
    chk("R11 status", status_o, 8'h00);
    wait_idle(n);
    chk("R11 remaining cycles", n, ERASE_CYC - 8);
    chk("R14 reserved", status_o[2:0], 0);
  endtask

  task automatic t_errors;
    int n;
    eng_fail = 1'b1;
    wr(T0, 8'h40, 0); wr(T0, 8'h11, 0); wait_idle(n);
    chk("R12 program fail", status_o, 8'h90);
    eng_fail = 1'b0; eng_ovp = 1'b1;
    wr(T0, 8'h50, 0);
    chk("R13 clear", status_o, 8'h80);
    wr(T0, 8'h40, 0); wr(T0, 8'h22, 0); wait_idle(n);
    chk("R12 over-program", status_o, 8'h88);
    eng_ovp = 1'b0;
    wr(T0, 8'h40, 0); wr(T0, 8'h23, 0); wait_idle(n);
    chk("R13 sticky", status_o, 8'h88);
    wr(T0, 8'h50, 0);
    eng_fail = 1'b1;
    wr(T1, 8'h20, 0); wr(T1, 8'hD0, 0); wait_idle(n);
    chk("R12 erase fail", status_o, 8'hA0);
    eng_fail = 1'b0;
    wr(T1, 8'h50, 0);
    chk("R13 clear erase", status_o, 8'h80);
    wr(T0, 8'hFF, 0); wr(T1, 8'hFF, 0);
  endtask

  task automatic t_lock;
    wr(T1, 8'h20, 0);
    wr(T1, 8'hD0, 1);
    chk("R8 no start", erase_start_o, 0);
    chk("R8 status", status_o, 8'hB0);
    chk("R8 mode", mode_o[3:2], 1);
    chk("R8 idle", busy_o, 0);
    wr(T1, 8'h50, 0); wr(T1, 8'hFF, 0);
  endtask

  task automatic t_seq;
    wr(T0, 8'h20, 0);
    wr(T0, 8'hFF, 0);
    chk("R9 no start", erase_start_o, 0);
    chk("R9 status", status_o, 8'hB0);
    chk("R14 reserved", status_o[2:0], 0);
    wr(T0, 8'h90, 0);
    chk("R9 back to decode", mode_o[1:0], 2);
    wr(T0, 8'h50, 0); wr(T0, 8'hFF, 0);
  endtask

  task automatic t_pd;
    wr(T1, 8'h20, 0); wr(T1, 8'hD0, 0);
    eng_fail = 1'b0;
    repeat (2) @(negedge clk);
    pd_n = 1'b0;
    @(negedge clk);
    pd_n = 1'b1;
    chk("R1 abort busy", busy_o, 0);
    chk("R1 abort status", status_o, 8'h80);
    chk("R1 abort mode", mode_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_word();
    t_word_bank1();
    t_page();
    t_erase();
    t_suspend();
    t_errors();
    t_lock();
    t_seq();
    t_pd();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule